// File: doc/BRIEF.md
# Execute-Stage Branch Resolution and Commit Unit

This block sits at the execute stage of a short in-order pipeline and decides, for each instruction handed over by the ALU, whether it commits and whether the instructions fetched behind it must be thrown away. It accepts at most one instruction per cycle through a valid/ready handshake. For a conditional branch it works out the real condition from the two integer operands. It then compares the real direction and target with what the front end predicted. When they differ, it raises a redirect request towards the fetch unit that carries the corrected next PC.

An interrupt or exception flagged on the incoming instruction also raises a redirect. This redirect goes to the trap vector and has priority over any mispredict. The PC of the trapped instruction is latched for the exception PC register. The instruction that mispredicts or traps still commits; only the younger work in flight is cancelled. The redirect stays asserted until the fetch unit takes it, and no new instruction is accepted while it is pending. All outputs are registered, and reset is synchronous and active high.

Top module: `brc_commit_unit`

## Requirements
- R1: The 3-bit branch kind is decoded as 0 none, 1 equal, 2 not-equal, 3 signed less-than, 4 signed greater-or-equal, 5 unsigned less-than, 6 unsigned greater-or-equal, 7 none. For kinds 1 to 6 the real direction is taken exactly when the condition holds between operand A and operand B.
- R2: A branch whose real direction matches the prediction, and whose predicted target is correct when taken, commits with no redirect and no mispredict flag.
- R3: A branch predicted taken but really not taken redirects to its PC plus 4. A branch predicted not taken but really taken redirects to its PC plus the sign-extended 13-bit immediate.
- R4: A branch that is predicted taken and really taken, but whose predicted target differs from PC plus the sign-extended immediate, redirects to that computed target and is flagged as mispredicted.
- R5: An instruction that mispredicts or traps is itself reported as committed, with its own PC, in the cycle after its handshake.
- R6: A redirect, once raised, holds its valid and PC until the fetch ready is seen high. While it is pending, the ALU ready output is low and any offered instruction is ignored, so no commit is reported.
- R7: An interrupt or exception request sampled with an accepted instruction redirects to the trap vector, sets the trap flag instead of the mispredict flag even when the branch also mispredicts, and latches the instruction's PC on the exception PC output.
- R8: Instructions of kind 0 or 7 commit with no redirect, whatever the prediction inputs say.
- R9: Reset clears any pending redirect and the commit and trap flags, and holds the ALU ready output low while it is asserted.
- R10: Instructions accepted on consecutive cycles are reported as committed in the same order, one per cycle, each one cycle after its handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | ALU offers an instruction |
| ex_ready | output | 1 | Unit can accept an instruction this cycle |
| ex_kind | input | 3 | Branch kind code (see R1) |
| ex_opa | input | XLEN | First integer operand |
| ex_opb | input | XLEN | Second integer operand |
| ex_pred_tk | input | 1 | Front end predicted the branch taken |
| ex_pred_tgt | input | PCW | Predicted target when predicted taken |
| ex_pc | input | PCW | PC of the offered instruction |
| ex_imm | input | IMMW | Branch offset, sign-extended to PCW |
| irq_req | input | 1 | Interrupt to be taken on the offered instruction |
| exc_req | input | 1 | Exception raised by the offered instruction |
| trap_vec | input | PCW | Trap handler address |
| fe_redir_valid | output | 1 | Redirect request to the fetch unit |
| fe_redir_ready | input | 1 | Fetch unit takes the redirect |
| fe_redir_pc | output | PCW | Corrected next PC |
| cmt_valid | output | 1 | An instruction committed |
| cmt_pc | output | PCW | PC of the committed instruction |
| cmt_mispred | output | 1 | Committed instruction was a mispredicted branch |
| cmt_trap | output | 1 | Committed instruction took a trap |
| epc_pc | output | PCW | PC of the last trapped instruction |

## Verification
The hardest situation to reach from the ports is an instruction offered while a redirect is still waiting for the fetch unit. It must be refused without leaving any trace in the commit outputs, and the pending PC must not move. The stimulus reaches this point by following every mispredicting or trapping instruction in the sweep with zero to two cycles in which fetch ready stays low. In those cycles the ALU side keeps offering a fresh instruction. Reset is also applied once in the middle of such a pending redirect. The operand sweep covers every kind against sign-boundary values, so that signed and unsigned orderings disagree.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_EQ   = 3'd1,
    BK_NE   = 3'd2,
    BK_LT   = 3'd3,
    BK_GE   = 3'd4,
    BK_LTU  = 3'd5,
    BK_GEU  = 3'd6,
    BK_RSV  = 3'd7
  } br_kind_e;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            is_branch,
  output logic            taken
);
  import brc_pkg::*;

  logic eq_w, lts_w, ltu_w;

  assign eq_w  = (opa == opb);
  assign lts_w = ($signed(opa) < $signed(opb));
  assign ltu_w = (opa < opb);

  always_comb begin
    is_branch = 1'b1;
    taken     = 1'b0;
    case (kind)
      BK_EQ:   taken = eq_w;
      BK_NE:   taken = !eq_w;
      BK_LT:   taken = lts_w;
      BK_GE:   taken = !lts_w;
      BK_LTU:  taken = ltu_w;
      BK_GEU:  taken = !ltu_w;
      default: is_branch = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
  parameter int PCW  = 32,
  parameter int IMMW = 13
) (
  input  logic [PCW-1:0]  pc,
  input  logic [IMMW-1:0] imm,
  output logic [PCW-1:0]  seq_pc,
  output logic [PCW-1:0]  tgt_pc
);
  localparam int EXTW = PCW - IMMW;

  logic [PCW-1:0] imm_ext;

  assign imm_ext = {{EXTW{imm[IMMW-1]}}, imm};
  assign seq_pc  = pc + PCW'(4);
  assign tgt_pc  = pc + imm_ext;

endmodule

// File: rtl/brc_resolve.sv
module brc_resolve #(
  parameter int PCW = 32
) (
  input  logic           is_branch,
  input  logic           taken,
  input  logic           pred_tk,
  input  logic [PCW-1:0] pred_tgt,
  input  logic [PCW-1:0] seq_pc,
  input  logic [PCW-1:0] tgt_pc,
  input  logic           trap_in,
  input  logic [PCW-1:0] trap_vec,
  output logic           need_redir,
  output logic           mispred,
  output logic [PCW-1:0] redir_pc
);
  logic dir_miss, tgt_miss;

  assign dir_miss = is_branch && (taken != pred_tk);
  assign tgt_miss = is_branch && taken && pred_tk && (pred_tgt != tgt_pc);

  always_comb begin
    mispred    = dir_miss || tgt_miss;
    need_redir = trap_in || mispred;
    if (trap_in) begin
      redir_pc = trap_vec;
      mispred  = 1'b0;
    end else if (taken) begin
      redir_pc = tgt_pc;
    end else begin
      redir_pc = seq_pc;
    end
  end

endmodule

// File: rtl/brc_redirect_reg.sv
module brc_redirect_reg #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set,
  input  logic [PCW-1:0] set_pc,
  input  logic           ack,
  output logic           valid,
  output logic [PCW-1:0] pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
    end else if (ack) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (set) pc <= set_pc;
  end

  AST_REDIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ack) |=> (valid && $stable(pc))) else $error("redirect dropped"); // R6

endmodule

// File: rtl/brc_commit_unit.sv
module brc_commit_unit #(
  parameter int XLEN = 32,
  parameter int PCW  = 32,
  parameter int IMMW = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_valid,
  output logic            ex_ready,
  input  logic [2:0]      ex_kind,
  input  logic [XLEN-1:0] ex_opa,
  input  logic [XLEN-1:0] ex_opb,
  input  logic            ex_pred_tk,
  input  logic [PCW-1:0]  ex_pred_tgt,
  input  logic [PCW-1:0]  ex_pc,
  input  logic [IMMW-1:0] ex_imm,
  input  logic            irq_req,
  input  logic            exc_req,
  input  logic [PCW-1:0]  trap_vec,
  output logic            fe_redir_valid,
  input  logic            fe_redir_ready,
  output logic [PCW-1:0]  fe_redir_pc,
  output logic            cmt_valid,
  output logic [PCW-1:0]  cmt_pc,
  output logic            cmt_mispred,
  output logic            cmt_trap,
  output logic [PCW-1:0]  epc_pc
);

  logic           is_br, real_tk, trap_w, need_redir, mis_w, accept;
  logic [PCW-1:0] seq_pc, tgt_pc, redir_pc;

  assign trap_w   = irq_req || exc_req;
  assign ex_ready = !rst && !fe_redir_valid;
  assign accept   = ex_valid && ex_ready;

  brc_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind(ex_kind), .opa(ex_opa), .opb(ex_opb),
    .is_branch(is_br), .taken(real_tk)
  );

  brc_target_calc #(.PCW(PCW), .IMMW(IMMW)) u_tgt (
    .pc(ex_pc), .imm(ex_imm), .seq_pc(seq_pc), .tgt_pc(tgt_pc)
  );

  brc_resolve #(.PCW(PCW)) u_res (
    .is_branch(is_br), .taken(real_tk), .pred_tk(ex_pred_tk),
    .pred_tgt(ex_pred_tgt), .seq_pc(seq_pc), .tgt_pc(tgt_pc),
    .trap_in(trap_w), .trap_vec(trap_vec),
    .need_redir(need_redir), .mispred(mis_w), .redir_pc(redir_pc)
  );

  brc_redirect_reg #(.PCW(PCW)) u_redir (
    .clk(clk), .rst(rst), .set(accept && need_redir), .set_pc(redir_pc),
    .ack(fe_redir_ready), .valid(fe_redir_valid), .pc(fe_redir_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid   <= 1'b0;
      cmt_mispred <= 1'b0;
      cmt_trap    <= 1'b0;
    end else begin
      cmt_valid   <= accept;
      cmt_mispred <= accept && mis_w;
      cmt_trap    <= accept && trap_w;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) cmt_pc <= ex_pc;
    if (accept && trap_w) epc_pc <= ex_pc;
  end

  AST_COMMIT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_ready) |=> cmt_valid) else $error("commit missing"); // R10
  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    fe_redir_valid |-> !ex_ready) else $error("ready while redirect"); // R6
  AST_NO_CMT_PEND: assert property (@(posedge clk) disable iff (rst)
    fe_redir_valid |=> !cmt_valid) else $error("commit during redirect"); // R6
  AST_TRAP_REDIR: assert property (@(posedge clk) disable iff (rst)
    cmt_trap |-> (fe_redir_valid && fe_redir_pc == $past(trap_vec))) else $error("trap redirect"); // R7
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !(cmt_trap && cmt_mispred)) else $error("two causes"); // R7
  AST_CLEAN_NO_REDIR: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !cmt_mispred && !cmt_trap) |-> !fe_redir_valid) else $error("spurious redirect"); // R2

endmodule

// File: tb/tb_brc_commit_unit.sv
module tb_brc_commit_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        ex_valid = 1'b0, ex_ready;
  logic [2:0]  ex_kind = '0;
  logic [31:0] ex_opa = '0, ex_opb = '0, ex_pred_tgt = '0, ex_pc = '0, trap_vec = '0;
  logic        ex_pred_tk = 1'b0, irq_req = 1'b0, exc_req = 1'b0;
  logic [12:0] ex_imm = '0;
  logic        fe_redir_valid, fe_redir_ready = 1'b0;
  logic [31:0] fe_redir_pc, cmt_pc, epc_pc;
  logic        cmt_valid, cmt_mispred, cmt_trap;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  brc_commit_unit dut (
    .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_ready(ex_ready),
    .ex_kind(ex_kind), .ex_opa(ex_opa), .ex_opb(ex_opb),
    .ex_pred_tk(ex_pred_tk), .ex_pred_tgt(ex_pred_tgt), .ex_pc(ex_pc),
    .ex_imm(ex_imm), .irq_req(irq_req), .exc_req(exc_req), .trap_vec(trap_vec),
    .fe_redir_valid(fe_redir_valid), .fe_redir_ready(fe_redir_ready),
    .fe_redir_pc(fe_redir_pc), .cmt_valid(cmt_valid), .cmt_pc(cmt_pc),
    .cmt_mispred(cmt_mispred), .cmt_trap(cmt_trap), .epc_pc(epc_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_taken(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      3'd1: return a == b;
      3'd2: return a != b;
      3'd3: return $signed(a) < $signed(b);
      3'd4: return $signed(a) >= $signed(b);
      3'd5: return a < b;
      3'd6: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_instr(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b,
                           input bit pt, input logic [31:0] ptgt, input logic [31:0] pc,
                           input logic [12:0] imm, input bit irq, input bit exc,
                           input logic [31:0] tv, input int hold);
    bit is_br, tk, trap, mis, redir;
    logic [31:0] tgt, rpc;
    is_br = (k >= 3'd1) && (k <= 3'd6);
    tk    = ref_taken(k, a, b);
    tgt   = pc + {{19{imm[12]}}, imm};
    trap  = irq || exc;
    mis   = is_br && ((tk != pt) || (tk && pt && ptgt != tgt));
    redir = trap || mis;
    rpc   = trap ? tv : (tk ? tgt : pc + 32'd4);
    @(negedge clk);
    chk("R6 ready idle", 32'(ex_ready), 32'd1);
    ex_valid = 1'b1; ex_kind = k; ex_opa = a; ex_opb = b; ex_pred_tk = pt;
    ex_pred_tgt = ptgt; ex_pc = pc; ex_imm = imm; irq_req = irq; exc_req = exc; trap_vec = tv;
    @(negedge clk);
    ex_valid = 1'b0; irq_req = 1'b0; exc_req = 1'b0;
    chk("R5 commit valid", 32'(cmt_valid), 32'd1);
    chk("R10 commit pc", cmt_pc, pc);
    if (!is_br && !trap) chk("R8 no redirect", 32'(fe_redir_valid), 32'd0);
    else if (trap)       chk("R7 trap redirect", 32'(fe_redir_valid), 32'd1);
    else                 chk("R1 R2 redirect", 32'(fe_redir_valid), 32'(redir));
    chk("R1 mispred flag", 32'(cmt_mispred), 32'(mis && !trap));
    chk("R7 trap flag", 32'(cmt_trap), 32'(trap));
    if (trap) begin
      chk("R7 epc", epc_pc, pc);
      chk("R7 trap pc", fe_redir_pc, tv);
    end else if (redir) chk("R3 redirect pc", fe_redir_pc, rpc);
    if (fe_redir_valid) begin
      for (int h = 0; h < hold; h++) begin
        ex_valid = 1'b1; ex_pc = 32'hDEAD_0000 + 32'(h); ex_kind = 3'd0;
        @(negedge clk);
        chk("R6 redirect held", 32'(fe_redir_valid), 32'd1);
        chk("R6 pc stable", fe_redir_pc, rpc);
        chk("R6 ready low", 32'(ex_ready), 32'd0);
        chk("R6 ignored commit", 32'(cmt_valid), 32'd0);
      end
      ex_valid = 1'b0; fe_redir_ready = 1'b1;
      @(negedge clk);
      fe_redir_ready = 1'b0;
      chk("R6 redirect taken", 32'(fe_redir_valid), 32'd0);
      chk("R6 ready back", 32'(ex_ready), 32'd1);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    int idx;
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset redirect", 32'(fe_redir_valid), 32'd0);
    chk("R9 reset commit", 32'(cmt_valid), 32'd0);
    chk("R9 reset ready", 32'(ex_ready), 32'd0);
    rst = 1'b0;

    idx = 0;
    for (int k = 0; k < 8; k++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
          for (int p = 0; p < 2; p++) begin
            logic [31:0] pc;
            logic [12:0] imm;
            pc  = 32'h0000_1000 + 32'(idx * 4);
            imm = idx[0] ? 13'h1FF0 : 13'h0040;
            run_instr(3'(k), vals[ia], vals[ib], p[0],
                      p[0] ? pc + {{19{imm[12]}}, imm} : 32'h0, pc, imm,
                      1'b0, 1'b0, 32'h0, idx % 3);
            idx++;
          end

    // R4: direction right, target wrong
    run_instr(3'd1, 32'd7, 32'd7, 1'b1, 32'h0000_9999, 32'h0000_2000, 13'h0100, 1'b0, 1'b0, 32'h0, 1);
    // R7: interrupt on a mispredicting branch
    run_instr(3'd2, 32'd3, 32'd4, 1'b0, 32'h0, 32'h0000_3000, 13'h0020, 1'b1, 1'b0, 32'h0000_0080, 2);
    // R7: exception on a plain instruction
    run_instr(3'd0, 32'd0, 32'd0, 1'b0, 32'h0, 32'h0000_3100, 13'h0, 1'b0, 1'b1, 32'h0000_0100, 0);
    // R8: plain instruction with a taken prediction
    run_instr(3'd7, 32'd1, 32'd2, 1'b1, 32'h0000_5555, 32'h0000_3200, 13'h0010, 1'b0, 1'b0, 32'h0, 0);

    // R10: back-to-back commits in order
    @(negedge clk);
    ex_valid = 1'b1; ex_kind = 3'd0; ex_pc = 32'h0000_4000;
    @(negedge clk);
    chk("R10 first", cmt_pc, 32'h0000_4000);
    ex_pc = 32'h0000_4004;
    @(negedge clk);
    chk("R10 second", cmt_pc, 32'h0000_4004);
    chk("R10 second valid", 32'(cmt_valid), 32'd1);
    ex_valid = 1'b0;

    // R9: reset while a redirect is pending
    @(negedge clk);
    ex_valid = 1'b1; ex_kind = 3'd1; ex_opa = 32'd1; ex_opb = 32'd2; ex_pred_tk = 1'b1;
    ex_pc = 32'h0000_5000;
    @(negedge clk);
    ex_valid = 1'b0;
    chk("R3 pending before reset", 32'(fe_redir_valid), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 redirect cleared", 32'(fe_redir_valid), 32'd0);
    chk("R9 commit cleared", 32'(cmt_valid), 32'd0);
    chk("R9 ready low", 32'(ex_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 ready after", 32'(ex_ready), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule